// File: doc/BRIEF.md
# Virtual DMA Channel Controller

This block is one channel of a DMA engine that carries the data phase of PIO-mode storage commands as though it were a DMA transfer. Software programs a byte count and then sets the start bit of the channel's command/status register. The engine then passes 32-bit words between a host-memory stream and a device PIO data stream until the count is used up. It signals completion through the command/status register and a channel status register, and it raises a level interrupt to the host.

Two interrupt causes are kept apart so that software can resolve the race between them. One is virtual-DMA completion. The other is an interrupt from the device, which can arrive while the transfer runs or just after it ends. A pending device interrupt persists after DMA is disabled, and only a read of the task-file register clears it. While no transfer is running, the channel-interrupt bit latches the device interrupt.

All data interfaces are valid/ready. A word moves only in a cycle where the source's valid and the sink's ready are both high. The data path is a combinational pass-through that is open only while a transfer is active. A source sees ready only when the sink is ready. A sink sees valid only when the source is valid. Either side can stall for any number of cycles without losing or repeating a word. The register access pins and the interrupt pins are plain signals.

Top module: `vdma_chan`

## Requirements
- R1: After reset, every register reads 0, host_irq is 0, and no stream valid or ready output is high.
- R2: Address 1 holds the byte count, which is writable only while idle. A write to address 0 with bit 0 = 1 starts a transfer only when the count is nonzero. Bit 16 of address 0 reads 1 while the transfer is active. With a count of 0, nothing starts.
- R3: Each accepted word reduces the count by 4. When 4 or fewer bytes remain, the next word is the last one, and the transfer ends after exactly ceil(count/4) words.
- R4: The byte enable is 4'b1111 on every word except a final partial word. On that word it is 4'b0001, 4'b0011 or 4'b0111 for 1, 2 or 3 remaining bytes.
- R5: Bit 3 of the value written to start the transfer selects the direction. 1 sends the device-receive stream to the memory-write stream. 0 sends the memory-read stream to the device-transmit stream. The streams of the other direction stay at valid = 0 and ready = 0.
- R6: A word moves only when the source's valid and the sink's ready are both high. The source's ready is 0 whenever the sink's ready is 0. Data passes through unchanged.
- R7: On the last word, bit 16 clears, bits 18 and 17 of address 0 set, bit 10 of address 2 sets, and host_irq goes to 1.
- R8: Writing 1 to bit 18 or bit 17 of address 0 clears that bit, and host_irq drops when both are clear. Writing 0 to these bits leaves them unchanged.
- R9: Writing 0x00 to bits [7:0] of address 0 stops the transfer. Bit 16 clears, no further words move, the remaining count is kept, and no completion bit sets.
- R10: A rising edge on dev_irq while idle sets bit 18 and host_irq. A rising edge during a transfer does not set bit 18.
- R11: Bit 11 of address 2 sets on any rising edge of dev_irq, whether or not a transfer is running. It stays set through DMA disable and through writes to bits 18/17. Only a read (reg_rd) of address 3 clears it.
- R12: Address 3 returns dev_status in bits [31:24], so the device DRQ flag (status bit 3) appears at bit 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dev_irq | input | 1 | Device interrupt line |
| dev_status | input | 8 | Device status byte |
| host_irq | output | 1 | Level interrupt to the host |
| dev_rx_valid | input | 1 | Device word available (device to memory) |
| dev_rx_ready | output | 1 | Device word accepted |
| dev_rx_data | input | 32 | Device word |
| mem_wr_valid | output | 1 | Memory write word valid |
| mem_wr_ready | input | 1 | Memory accepts write word |
| mem_wr_data | output | 32 | Memory write word |
| mem_wr_be | output | 4 | Memory write byte enables |
| mem_rd_valid | input | 1 | Memory read word available (memory to device) |
| mem_rd_ready | output | 1 | Memory read word accepted |
| mem_rd_data | input | 32 | Memory read word |
| dev_tx_valid | output | 1 | Device transmit word valid |
| dev_tx_ready | input | 1 | Device accepts transmit word |
| dev_tx_data | output | 32 | Device transmit word |
| dev_tx_be | output | 4 | Device transmit byte enables |

## Verification
The bench runs counts of 1, 3, 5 and 6 bytes so that every partial final word occurs. A wrong byte-enable rule, or a counter that subtracts a full word at the end, would mask the wrong bytes or move one word too many. The sinks stall on alternate cycles, so a source ready that ignores the sink would drop words. A device interrupt is raised during a running transfer, and the transfer is then aborted. A design that latched that interrupt into bit 18, or cleared bit 11 on abort or on a status write, would either fake a completion or lose the device interrupt. A zero-value write checks that the clear bits act only on 1s.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [1:0] {
    A_BM   = 2'd0,
    A_CNT  = 2'd1,
    A_STAT = 2'd2,
    A_TF   = 2'd3
  } vdma_addr_e;

  localparam int BM_START  = 0;
  localparam int BM_DIR    = 3;
  localparam int BM_ACTIVE = 16;
  localparam int BM_VIRQ   = 17;
  localparam int BM_INT    = 18;
  localparam int ST_VDONE  = 10;
  localparam int ST_DEVINT = 11;
endpackage

// File: rtl/vdma_count.sv
module vdma_count #(
  parameter int CNT_W = 32,
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             beat,
  output logic [CNT_W-1:0] remaining,
  output logic [BYTES-1:0] be,
  output logic             last
);
  logic [CNT_W-1:0] step;

  assign last = (remaining <= CNT_W'(BYTES));
  assign step = last ? remaining : CNT_W'(BYTES);

  always_comb begin
    for (int i = 0; i < BYTES; i++) begin
      be[i] = !last || (CNT_W'(i) < remaining);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      remaining <= '0;
    else if (load)   remaining <= load_val;
    else if (beat)   remaining <= remaining - step;
  end

  // R3: a word never moves with nothing left to send
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (remaining != '0));
endmodule

// File: rtl/vdma_xfer.sv
module vdma_xfer #(
  parameter int DATA_W = 32
) (
  input  logic              busy,
  input  logic              dir,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic [DATA_W-1:0] dev_rx_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_rd_valid,
  output logic              mem_rd_ready,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  output logic [DATA_W-1:0] dev_tx_data,
  output logic              beat
);
  logic up_en, dn_en;

  assign up_en = busy & dir;
  assign dn_en = busy & ~dir;

  assign mem_wr_valid = up_en & dev_rx_valid;
  assign dev_rx_ready = up_en & mem_wr_ready;
  assign mem_wr_data  = dev_rx_data;

  assign dev_tx_valid = dn_en & mem_rd_valid;
  assign mem_rd_ready = dn_en & dev_tx_ready;
  assign dev_tx_data  = mem_rd_data;

  assign beat = (up_en & dev_rx_valid & mem_wr_ready) |
                (dn_en & mem_rd_valid & dev_tx_ready);
endmodule

// File: rtl/vdma_irq.sv
module vdma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic done,
  input  logic dev_irq,
  input  logic tf_read,
  input  logic clr_int,
  input  logic clr_vdma,
  output logic dma_int,
  output logic vdma_irq,
  output logic dev_pend,
  output logic host_irq
);
  logic irq_prev, irq_edge;

  assign irq_edge = dev_irq & ~irq_prev;
  assign host_irq = dma_int | vdma_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev <= 1'b0;
      dma_int  <= 1'b0;
      vdma_irq <= 1'b0;
      dev_pend <= 1'b0;
    end else begin
      irq_prev <= dev_irq;
      if (done || (irq_edge && !busy)) dma_int <= 1'b1;
      else if (clr_int)                dma_int <= 1'b0;
      if (done)          vdma_irq <= 1'b1;
      else if (clr_vdma) vdma_irq <= 1'b0;
      if (irq_edge)     dev_pend <= 1'b1;
      else if (tf_read) dev_pend <= 1'b0;
    end
  end

  // R7: completion raises both status bits
  a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (dma_int && vdma_irq));
  // R8: a write-one clear takes effect
  a_r8_vdma_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vdma && !done) |=> !vdma_irq);
  // R11: pending device interrupt is kept until a task-file read
  a_r11_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_pend && !tf_read) |=> dev_pend);
  // R10: a device edge during a transfer does not latch into bit 18
  a_r10_busy_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !dma_int && $rose(dev_irq)) |=> !dma_int);
endmodule

// File: rtl/vdma_chan.sv
module vdma_chan #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dev_irq,
  input  logic [7:0]        dev_status,
  output logic              host_irq,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic [DATA_W-1:0] dev_rx_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [DATA_W/8-1:0] mem_wr_be,
  input  logic              mem_rd_valid,
  output logic              mem_rd_ready,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  output logic [DATA_W-1:0] dev_tx_data,
  output logic [DATA_W/8-1:0] dev_tx_be
);
  import vdma_pkg::*;
  localparam int BYTES = DATA_W / 8;

  logic             busy, dir;
  logic             beat, last, done;
  logic [CNT_W-1:0] remaining;
  logic [BYTES-1:0] be;
  logic             dma_int, vdma_irq_b, dev_pend;
  logic             wr_bm, wr_cnt, tf_read, start, stop;

  assign wr_bm   = reg_wr && (reg_addr == A_BM);
  assign wr_cnt  = reg_wr && (reg_addr == A_CNT) && !busy;
  assign tf_read = reg_rd && (reg_addr == A_TF);
  assign start   = wr_bm && reg_wdata[BM_START] && !busy && (remaining != '0);
  assign stop    = wr_bm && (reg_wdata[7:0] == 8'h00);
  assign done    = beat && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      dir  <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      dir  <= reg_wdata[BM_DIR];
    end else if (stop || done) begin
      busy <= 1'b0;
    end
  end

  vdma_count #(.CNT_W(CNT_W), .BYTES(BYTES)) u_count (
    .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(reg_wdata[CNT_W-1:0]),
    .beat(beat), .remaining(remaining), .be(be), .last(last)
  );

  vdma_xfer #(.DATA_W(DATA_W)) u_xfer (
    .busy(busy), .dir(dir),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .beat(beat)
  );

  vdma_irq u_irq (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .dev_irq(dev_irq),
    .tf_read(tf_read), .clr_int(wr_bm && reg_wdata[BM_INT]),
    .clr_vdma(wr_bm && reg_wdata[BM_VIRQ]),
    .dma_int(dma_int), .vdma_irq(vdma_irq_b), .dev_pend(dev_pend), .host_irq(host_irq)
  );

  assign mem_wr_be = be;
  assign dev_tx_be = be;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_BM: begin
        reg_rdata[BM_INT]    = dma_int;
        reg_rdata[BM_VIRQ]   = vdma_irq_b;
        reg_rdata[BM_ACTIVE] = busy;
        reg_rdata[BM_DIR]    = dir;
        reg_rdata[BM_START]  = busy;
      end
      A_CNT:  reg_rdata = 32'(remaining);
      A_STAT: begin
        reg_rdata[ST_DEVINT] = dev_pend;
        reg_rdata[ST_VDONE]  = vdma_irq_b;
      end
      default: reg_rdata[31:24] = dev_status;
    endcase
  end

  // R9: a zero command byte stops the transfer
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_BM && reg_wdata[7:0] == 8'h00) |=> !busy);
  // R4: an offered word always enables at least one byte
  a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid || dev_tx_valid) |-> (be != '0));
  // R5: only one direction is ever offered
  a_r5_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_valid && dev_tx_valid));
  // R7: completion leaves the engine idle
  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && remaining == '0));
endmodule

// File: tb/vdma_chan_tb_top.sv
`timescale 1ns/100ps
module vdma_chan_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic dev_irq = 0;
  logic [7:0] dev_status = 8'h58;
  logic host_irq;
  logic dev_rx_valid = 0, dev_rx_ready;
  logic [31:0] dev_rx_data = 0;
  logic mem_wr_valid, mem_wr_ready = 0;
  logic [31:0] mem_wr_data;
  logic [3:0] mem_wr_be;
  logic mem_rd_valid = 0, mem_rd_ready;
  logic [31:0] mem_rd_data = 0;
  logic dev_tx_valid, dev_tx_ready = 0;
  logic [31:0] dev_tx_data;
  logic [3:0] dev_tx_be;

  int n_tests = 0, n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  vdma_chan dut_i (.*);

  // vector: count[44:13], dir[12], expected words[11:4], final byte enable[3:0]
  localparam logic [44:0] VEC [0:5] = '{
    {32'd8,  1'b1, 8'd2, 4'hF},
    {32'd5,  1'b1, 8'd2, 4'h1},
    {32'd6,  1'b0, 8'd2, 4'h3},
    {32'd3,  1'b0, 8'd1, 4'h7},
    {32'd1,  1'b1, 8'd1, 4'h1},
    {32'd16, 1'b0, 8'd4, 4'hF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_vec(input int idx);
    logic [31:0] cnt; logic dr; logic [7:0] ew; logic [3:0] lbe;
    int words; int k;
    logic sv, sr, srcr, bsy; logic [31:0] sd; logic [3:0] sbe;
    {cnt, dr, ew, lbe} = VEC[idx];
    wr(2'd1, cnt);
    wr(2'd0, 32'h1 | (32'(dr) << 3));
    rd(2'd0, rv);
    chk(rv[16] == 1'b1 && rv[3] == dr, "R2 active after start", rv, {15'd0, 1'b1, 12'd0, dr, 3'd1});
    words = 0; k = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      reg_addr = 2'd0;
      dev_rx_valid = 1; mem_rd_valid = 1;
      dev_rx_data = 32'hA000_0000 + k;
      mem_rd_data = 32'hB000_0000 + k;
      mem_wr_ready = dr ? c[0] : 1'b1;
      dev_tx_ready = dr ? 1'b1 : c[0];
      #1;
      bsy = reg_rdata[16];
      if (!bsy) break;
      sv   = dr ? mem_wr_valid : dev_tx_valid;
      sr   = dr ? mem_wr_ready : dev_tx_ready;
      sd   = dr ? mem_wr_data  : dev_tx_data;
      sbe  = dr ? mem_wr_be    : dev_tx_be;
      srcr = dr ? dev_rx_ready : mem_rd_ready;
      if (dr) chk(!dev_tx_valid && !mem_rd_ready, "R5 idle direction quiet", {dev_tx_valid, mem_rd_ready}, 0);
      else    chk(!mem_wr_valid && !dev_rx_ready, "R5 idle direction quiet", {mem_wr_valid, dev_rx_ready}, 0);
      if (!sr) chk(!srcr, "R6 backpressure", srcr, 0);
      if (sv && sr) begin
        chk(sd == (dr ? 32'hA000_0000 + k : 32'hB000_0000 + k), "R6 data pass", sd,
            dr ? 32'hA000_0000 + k : 32'hB000_0000 + k);
        chk(sbe == ((words == ew - 1) ? lbe : 4'hF), "R4 byte enable", sbe,
            (words == ew - 1) ? lbe : 4'hF);
        words++; k++;
      end
    end
    dev_rx_valid = 0; mem_rd_valid = 0; mem_wr_ready = 0; dev_tx_ready = 0;
    chk(words == ew, "R3 word count", words, ew);
    rd(2'd1, rv);
    chk(rv == 0, "R3 count exhausted", rv, 0);
    rd(2'd0, rv);
    chk(rv[18:16] == 3'b110 && host_irq, "R7 completion flags", {host_irq, rv[18:16]}, 4'b1110);
    rd(2'd2, rv);
    chk(rv[10] == 1'b1, "R7 status done bit", rv, 32'h400);
    wr(2'd0, 32'h0006_0000);
    rd(2'd0, rv);
    chk(rv[18:17] == 2'b00 && !host_irq, "R8 write-one clear", {host_irq, rv[18:17]}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), rv);
      chk(rv == 0, "R1 reset register", rv, 0);
    end
    chk(!host_irq && !mem_wr_valid && !dev_tx_valid && !dev_rx_ready && !mem_rd_ready,
        "R1 reset outputs", {host_irq, mem_wr_valid, dev_tx_valid, dev_rx_ready, mem_rd_ready}, 0);
    // R2 no start with zero count
    wr(2'd0, 32'h1);
    rd(2'd0, rv);
    chk(rv[16] == 0, "R2 zero count no start", rv, 0);

    for (int i = 0; i < 6; i++) run_vec(i);

    // R10/R11: device edge during a transfer, then abort (R9)
    wr(2'd1, 32'd8);
    wr(2'd0, 32'h1);
    @(negedge clk) dev_irq = 1;
    rd(2'd0, rv);
    chk(rv[18] == 0 && !host_irq, "R10 no latch while busy", {host_irq, rv[18]}, 0);
    rd(2'd2, rv);
    chk(rv[11] == 1, "R11 pending during transfer", rv, 32'h800);
    wr(2'd0, 32'h0);
    rd(2'd0, rv);
    chk(rv[18:16] == 3'b000, "R9 abort clears active, no completion", rv[18:16], 0);
    rd(2'd1, rv);
    chk(rv == 32'd8, "R9 count kept", rv, 8);
    wr(2'd0, 32'h0006_0000);
    rd(2'd2, rv);
    chk(rv[11] == 1 && rv[10] == 0, "R11 pending survives disable and clear", rv, 32'h800);
    // R12 task-file read and clear of R11
    @(negedge clk);
    reg_addr = 2'd3; reg_rd = 1;
    #1 rv = reg_rdata;
    chk(rv[31:24] == 8'h58 && rv[27], "R12 status byte and DRQ", rv, 32'h5800_0000);
    @(negedge clk) reg_rd = 0;
    rd(2'd2, rv);
    chk(rv[11] == 0, "R11 cleared by task-file read", rv, 0);
    // R10 idle latch
    @(negedge clk) dev_irq = 0;
    @(negedge clk) dev_irq = 1;
    rd(2'd0, rv);
    chk(rv[18] == 1 && host_irq, "R10 idle latch", {host_irq, rv[18]}, 2'b11);
    wr(2'd0, 32'h0);
    rd(2'd0, rv);
    chk(rv[18] == 1 && host_irq, "R8 zero write no effect", {host_irq, rv[18]}, 2'b11);
    wr(2'd0, 32'h0004_0000);
    rd(2'd0, rv);
    chk(rv[18] == 0 && !host_irq, "R8 clear latched bit", {host_irq, rv[18]}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule